// File: doc/BRIEF.md
# DRAM Strobe-Sequence Cycle Decoder

This block is the device-side front end of a small memory that sits behind a multiplexed-address strobe interface of the classic dynamic-memory kind. The interface has a row strobe, a column strobe, a write strobe and an output-enable strobe, all active low. A fast system clock samples the four asynchronous strobes through two-flop synchronizers. The block finds edges on the synchronized copies and sorts every row-strobe cycle into one of seven kinds, using only the order in which the strobe edges arrive.

It latches the row and column addresses and keeps an internal refresh row counter. It performs the read or write on a small register array and controls the enable of the tristate data pad. When each row-strobe cycle completes, the block emits a one-cycle valid pulse together with a cycle-kind code and the row that was acted on. This output serves integration checks and tracing.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset the data pad is not driven, no cycle pulse is present, and the refresh counter is 0, so the first counter-based refresh reports row 0.
- R2: Each rising edge of the row strobe that closes a cycle produces exactly one cycle_valid_o pulse of one clock. cycle_type_o then carries one of these codes: 0 read, 1 early write, 2 delayed write, 3 read-modify-write, 4 row-only refresh, 5 counter refresh, 6 hidden refresh.
- R3: A row-strobe cycle with the column strobe high throughout is reported as code 4. Its reported row is the address present when the row strobe fell.
- R4: If the write strobe is low when the column strobe falls, the data pad value is stored at that column fall. The pad stays undriven for the whole cycle even with output enable low.
- R5: With the write strobe high, a column fall reads the addressed cell. The pad is driven with the stored value only while both the column strobe and output enable are low, and it is released when either goes high.
- R6: If the write strobe falls while the column strobe is already low in a read cycle, and output enable was not low in that access, the pad value is stored at the write fall and the cycle is reported as code 2.
- R7: If output enable was low during the access before the write strobe fell, the read data appears first, the write at the write fall then stores the new value, and the cycle is reported as code 3.
- R8: A row fall with the column strobe already low and no preceding access still held is a counter refresh (code 5). The address pins are ignored, the reported row is the counter value, and the counter then increments. Repeated row cycles with the column strobe kept low refresh successive rows.
- R9: A row cycle started while the column strobe is still held low from a previous access is a hidden refresh (code 6). It uses and advances the counter, and the previously read data stays driven on the pad throughout.
- R10: The column address follows the address pins while the column strobe is high inside a row cycle, and it is frozen from the column fall. Address changes after that fall have no effect on the accessed cell.
- R11: The array cell is selected by the low ROW_SEL_W bits of the row address (3) concatenated with the low COL_SEL_W bits of the column address (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, much faster than the strobes |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low, asynchronous |
| cas_ni | input | 1 | Column strobe, active low, asynchronous |
| we_ni | input | 1 | Write strobe, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | ADDR_W (11) | Multiplexed row/column address |
| dq_i | input | DATA_W (8) | Data from the pad |
| dq_o | output | DATA_W (8) | Data to the pad |
| dq_oe_o | output | 1 | Pad driver enable |
| cycle_valid_o | output | 1 | One-clock pulse per completed row cycle |
| cycle_type_o | output | 3 | Kind of the completed cycle |
| cycle_row_o | output | ADDR_W (11) | Row acted on by the completed cycle |

## Verification
If the refresh counter is wrong, the error shows in cycle_row_o of the next counter or hidden refresh, four clocks after the row strobe rises. If the held-access flag is wrong, a hidden refresh is reported as code 5, or the pad drops during it. That is visible within one synchronizer delay of the row fall. If the column latch or write capture is wrong, the error stays hidden until the cell is read back, so every write is followed by a read of the same and of a neighbouring cell. The early/delayed decision is checked at the pad, which must stay undriven through an early write even with output enable low.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    CYC_READ   = 3'd0,
    CYC_EWR    = 3'd1,
    CYC_DWR    = 3'd2,
    CYC_RMW    = 3'd3,
    CYC_RONLY  = 3'd4,
    CYC_CBR    = 3'd5,
    CYC_HIDDEN = 3'd6
  } cyc_e;
endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
        s3_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign q_o[g]      = s2_q;
    assign q_prev_o[g] = s3_q;
  end
endmodule

// File: rtl/dcd_classifier.sv
module dcd_classifier
  import dcd_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int COL_SEL_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ras_s_i,
  input  logic                 ras_d_i,
  input  logic                 cas_s_i,
  input  logic                 cas_d_i,
  input  logic                 we_s_i,
  input  logic                 we_d_i,
  input  logic                 oe_s_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 wr_en_o,
  output logic                 rd_en_o,
  output logic [ADDR_W-1:0]    row_o,
  output logic [COL_SEL_W-1:0] col_o,
  output logic                 rd_valid_o,
  output logic                 valid_o,
  output logic [2:0]           type_o,
  output logic [ADDR_W-1:0]    out_row_o,
  output logic [ADDR_W-1:0]    ref_cnt_o
);
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  assign ras_fall = ras_d_i & ~ras_s_i;
  assign ras_rise = ~ras_d_i & ras_s_i;
  assign cas_fall = cas_d_i & ~cas_s_i;
  assign cas_rise = ~cas_d_i & cas_s_i;
  assign we_fall  = we_d_i & ~we_s_i;

  logic                 act_q, acc_q, rd_valid_q, oe_seen_q, held_q, valid_q;
  cyc_e                 typ_q;
  logic [2:0]           out_type_q;
  logic [ADDR_W-1:0]    row_q, out_row_q, ref_cnt_q;
  logic [COL_SEL_W-1:0] col_q;

  logic is_ref, access, early_wr, late_wr;
  assign is_ref   = (typ_q == CYC_CBR) || (typ_q == CYC_HIDDEN);
  assign access   = cas_fall & ~ras_s_i & act_q & ~is_ref;
  assign early_wr = access & ~we_s_i;
  assign late_wr  = we_fall & act_q & ~is_ref & ~cas_s_i & acc_q & (typ_q == CYC_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      acc_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      oe_seen_q  <= 1'b0;
      held_q     <= 1'b0;
      valid_q    <= 1'b0;
      typ_q      <= CYC_RONLY;
      out_type_q <= '0;
      row_q      <= '0;
      out_row_q  <= '0;
      ref_cnt_q  <= '0;
      col_q      <= '0;
    end else begin
      valid_q <= 1'b0;
      // column latch is transparent while CAS is high inside a row cycle
      if (!ras_s_i && cas_s_i) col_q <= addr_i[COL_SEL_W-1:0];
      if (rd_valid_q && !oe_s_i) oe_seen_q <= 1'b1;
      if (ras_fall) begin
        act_q <= 1'b1;
        acc_q <= 1'b0;
        if (!cas_s_i) begin
          typ_q <= held_q ? CYC_HIDDEN : CYC_CBR;
          row_q <= ref_cnt_q;
        end else begin
          typ_q <= CYC_RONLY;
          row_q <= addr_i;
        end
      end
      if (access) begin
        acc_q     <= 1'b1;
        held_q    <= 1'b1;
        oe_seen_q <= 1'b0;
        if (!we_s_i) begin
          typ_q      <= CYC_EWR;
          rd_valid_q <= 1'b0;
        end else begin
          typ_q      <= CYC_READ;
          rd_valid_q <= 1'b1;
        end
      end
      if (late_wr) begin
        typ_q      <= oe_seen_q ? CYC_RMW : CYC_DWR;
        rd_valid_q <= 1'b0;
      end
      if (cas_rise) begin
        rd_valid_q <= 1'b0;
        held_q     <= 1'b0;
        oe_seen_q  <= 1'b0;
      end
      if (ras_rise && act_q) begin
        act_q      <= 1'b0;
        valid_q    <= 1'b1;
        out_type_q <= typ_q;
        out_row_q  <= row_q;
        if (is_ref) ref_cnt_q <= ref_cnt_q + 1'b1;
      end
    end
  end

  assign wr_en_o    = early_wr | late_wr;
  assign rd_en_o    = access & we_s_i;
  assign row_o      = row_q;
  assign col_o      = col_q;
  assign rd_valid_o = rd_valid_q;
  assign valid_o    = valid_q;
  assign type_o     = out_type_q;
  assign out_row_o  = out_row_q;
  assign ref_cnt_o  = ref_cnt_q;
endmodule

// File: rtl/dcd_array.sv
module dcd_array #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (rd_en_i) rdata_q <= mem_q[idx_i];
      if (wr_en_i) mem_q[idx_i] <= wdata_i;
    end
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int ROW_SEL_W = 3,
  parameter int COL_SEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              cycle_valid_o,
  output logic [2:0]        cycle_type_o,
  output logic [ADDR_W-1:0] cycle_row_o
);
  localparam int IDX_W = ROW_SEL_W + COL_SEL_W;

  logic [3:0] strb_s, strb_d;
  logic       ras_s, cas_s, we_s, oe_s;
  logic       wr_en, rd_en, rd_valid;
  logic [ADDR_W-1:0]    row, ref_cnt;
  logic [COL_SEL_W-1:0] col;

  dcd_sync #(.W(4), .RST_VAL(4'hF)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({oe_ni, we_ni, cas_ni, ras_ni}),
    .q_o      (strb_s),
    .q_prev_o (strb_d)
  );
  assign ras_s = strb_s[0];
  assign cas_s = strb_s[1];
  assign we_s  = strb_s[2];
  assign oe_s  = strb_s[3];

  dcd_classifier #(.ADDR_W(ADDR_W), .COL_SEL_W(COL_SEL_W)) u_cls (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_s_i    (ras_s),
    .ras_d_i    (strb_d[0]),
    .cas_s_i    (cas_s),
    .cas_d_i    (strb_d[1]),
    .we_s_i     (we_s),
    .we_d_i     (strb_d[2]),
    .oe_s_i     (oe_s),
    .addr_i     (addr_i),
    .wr_en_o    (wr_en),
    .rd_en_o    (rd_en),
    .row_o      (row),
    .col_o      (col),
    .rd_valid_o (rd_valid),
    .valid_o    (cycle_valid_o),
    .type_o     (cycle_type_o),
    .out_row_o  (cycle_row_o),
    .ref_cnt_o  (ref_cnt)
  );

  dcd_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .idx_i   ({row[ROW_SEL_W-1:0], col}),
    .wdata_i (dq_i),
    .rdata_o (dq_o)
  );

  assign dq_oe_o = rd_valid & ~cas_s & ~oe_s;
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_ni,
  input logic              cas_ni,
  input logic              oe_ni,
  input logic              dq_oe_o,
  input logic              cycle_valid_o,
  input logic [2:0]        cycle_type_o,
  input logic [ADDR_W-1:0] cycle_row_o,
  input logic [ADDR_W-1:0] ref_cnt
);
  a_r5_drive_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!$past(cas_ni, 2) && !$past(oe_ni, 2)));

  a_r2_pulse_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_valid_o |-> ($past(ras_ni, 3) && !$past(ras_ni, 4)));

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_valid_o |=> !cycle_valid_o);

  a_r2_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_valid_o |-> (cycle_type_o <= 3'd6));

  a_r8_counter_moves_on_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_cnt != $past(ref_cnt)) |-> (cycle_valid_o &&
      (cycle_type_o == 3'd5 || cycle_type_o == 3'd6)));

  a_r8_refresh_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_valid_o && (cycle_type_o == 3'd5 || cycle_type_o == 3'd6))
      |-> (ref_cnt == ADDR_W'(cycle_row_o + 1'b1)));
endmodule

bind dram_cycle_decoder dcd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ras_ni        (ras_ni),
  .cas_ni        (cas_ni),
  .oe_ni         (oe_ni),
  .dq_oe_o       (dq_oe_o),
  .cycle_valid_o (cycle_valid_o),
  .cycle_type_o  (cycle_type_o),
  .cycle_row_o   (cycle_row_o),
  .ref_cnt       (ref_cnt)
);

// File: tb/dram_cycle_decoder_tb_top.sv
module dram_cycle_decoder_tb_top;
  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, cyc_valid;
  logic [2:0] cyc_type;
  logic [AW-1:0] cyc_row;

  int checks = 0;
  int errors = 0;
  int ref_exp = 0;
  logic [2+AW:0] exp_q [$];

  always #5 clk = ~clk;

  dram_cycle_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe),
    .cycle_valid_o(cyc_valid), .cycle_type_o(cyc_type), .cycle_row_o(cyc_row)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_cycle(input logic [2:0] t, input int row);
    exp_q.push_back({1'b0, t, AW'(row)});
  endtask

  // monitor: pop and compare on every cycle pulse (R2)
  always @(negedge clk) begin
    if (rst_n && cyc_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected pulse", int'(cyc_type), 7);
      end else begin
        logic [2+AW:0] e;
        e = exp_q.pop_front();
        check(cyc_type == e[AW+2:AW], "R2 cycle code", int'(cyc_type), int'(e[AW+2:AW]));
        check(cyc_row == e[AW-1:0], "R3/R8 cycle row", int'(cyc_row), int'(e[AW-1:0]));
      end
    end
  end

  task automatic open_row(input int r);
    addr = AW'(r); step();
    ras_n = 1'b0; step();
  endtask

  task automatic early_write(input int r, input int c, input logic [DW-1:0] d);
    open_row(r);
    addr = AW'(c); oe_n = 1'b0; step();
    we_n = 1'b0; dq_in = d; step();
    cas_n = 1'b0; step();
    check(dq_oe == 1'b0, "R4 early write keeps pad released", int'(dq_oe), 0);
    dq_in = 8'h00; step();
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; step();
    expect_cycle(3'd1, r);
    ras_n = 1'b1; step();
  endtask

  task automatic read_check(input int r, input int c, input logic [DW-1:0] exp, input bit hold);
    open_row(r);
    addr = AW'(c); oe_n = 1'b0; step();
    cas_n = 1'b0; step();
    check(dq_oe == 1'b1, "R5 read drives pad", int'(dq_oe), 1);
    check(dq_out == exp, "R5/R11 read data", int'(dq_out), int'(exp));
    expect_cycle(3'd0, r);
    if (!hold) begin
      cas_n = 1'b1; step();
      check(dq_oe == 1'b0, "R5 release on column rise", int'(dq_oe), 0);
      oe_n = 1'b1;
    end
    ras_n = 1'b1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    check(dq_oe == 1'b0, "R1 pad released after reset", int'(dq_oe), 0);
    check(cyc_valid == 1'b0, "R1 no pulse after reset", int'(cyc_valid), 0);

    // R4 early write, R5 read back
    early_write(2, 5, 8'hA5);
    read_check(2, 5, 8'hA5, 1'b0);
    read_check(2, 4, 8'h00, 1'b0);

    // R5 output enable high keeps pad released during a read
    open_row(2); addr = AW'(5); step();
    cas_n = 1'b0; step();
    check(dq_oe == 1'b0, "R5 no drive with OE high", int'(dq_oe), 0);
    oe_n = 1'b0; step();
    check(dq_oe == 1'b1, "R5 drive once OE low", int'(dq_oe), 1);
    oe_n = 1'b1; step();
    check(dq_oe == 1'b0, "R5 release on OE high", int'(dq_oe), 0);
    cas_n = 1'b1; step();
    expect_cycle(3'd0, 2); ras_n = 1'b1; step();

    // R6 delayed write
    open_row(3); addr = AW'(1); step();
    cas_n = 1'b0; step();
    dq_in = 8'h3C; step();
    we_n = 1'b0; step();
    dq_in = 8'h00; cas_n = 1'b1; we_n = 1'b1; step();
    expect_cycle(3'd2, 3); ras_n = 1'b1; step();
    read_check(3, 1, 8'h3C, 1'b0);

    // R7 read-modify-write
    open_row(3); addr = AW'(1); oe_n = 1'b0; step();
    cas_n = 1'b0; step();
    check(dq_out == 8'h3C, "R7 old data shown first", int'(dq_out), 8'h3C);
    oe_n = 1'b1; step();
    dq_in = 8'hC3; we_n = 1'b0; step();
    dq_in = 8'h00; cas_n = 1'b1; we_n = 1'b1; step();
    expect_cycle(3'd3, 3); ras_n = 1'b1; step();
    read_check(3, 1, 8'hC3, 1'b0);

    // R3 row-only refresh
    expect_cycle(3'd4, 7);
    open_row(7); ras_n = 1'b1; step();

    // R8 counter refresh, twice with column strobe held low, address ignored
    addr = AW'(9); cas_n = 1'b0; step();
    expect_cycle(3'd5, ref_exp); ref_exp++;
    ras_n = 1'b0; step(); ras_n = 1'b1; step();
    expect_cycle(3'd5, ref_exp); ref_exp++;
    ras_n = 1'b0; step();
    check(dq_oe == 1'b0, "R8 no drive during refresh", int'(dq_oe), 0);
    ras_n = 1'b1; step();
    cas_n = 1'b1; step();

    // R9 hidden refresh after a read with column strobe held
    read_check(2, 5, 8'hA5, 1'b1);
    addr = AW'(6);
    expect_cycle(3'd6, ref_exp); ref_exp++;
    ras_n = 1'b0; step();
    check(dq_oe == 1'b1, "R9 data stays driven", int'(dq_oe), 1);
    check(dq_out == 8'hA5, "R9 data unchanged", int'(dq_out), 8'hA5);
    ras_n = 1'b1; step();
    cas_n = 1'b1; oe_n = 1'b1; step();

    // R10 column latch transparency and freeze
    open_row(4);
    addr = AW'(0); step();
    addr = AW'(6); step();
    we_n = 1'b0; dq_in = 8'h66; step();
    cas_n = 1'b0; step();
    addr = AW'(0); step();
    dq_in = 8'h00; cas_n = 1'b1; we_n = 1'b1; step();
    expect_cycle(3'd1, 4); ras_n = 1'b1; step();
    read_check(4, 6, 8'h66, 1'b0);
    read_check(4, 0, 8'h00, 1'b0);

    // R8 counter continues after hidden refresh
    cas_n = 1'b0; step();
    expect_cycle(3'd5, ref_exp); ref_exp++;
    ras_n = 1'b0; step(); ras_n = 1'b1; step();
    cas_n = 1'b1; step();

    step();
    check(exp_q.size() == 0, "R2 all cycles reported", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule